// File: doc/BRIEF.md
# SPI Slave with Character-Length Guard

This block is a synchronous SPI slave for a five-wire link: a serial clock, a data input from the master, a data output to the master, an active-low chip select and a slave-ready output. The host side loads the next outgoing word with a write strobe and collects each received word from a receive buffer with a valid flag. The character length is programmable. Data moves most significant bit first in the idle-low, sample-on-rising mode. All link pins are brought into the system clock domain through a two-stage synchroniser, so the system clock must run at least four times faster than the serial clock.

The slave watches for the chip select being released while a character is only partly shifted. In that case it stops driving its data output. It can also release the ready line. Any further serial clock edge seen while deselected abandons the partial character and latches a sticky length-error flag, which can raise an interrupt. Tri-state pins are modelled as a value plus an output-enable.

Top module: `spi_lenchk_slave`

## Requirements
- R1: After synchronous reset: `miso_oe`=0, `rdy_o`=1, `rx_valid`=0, `rx_data`=0, `len_err`=0, `irq`=0.
- R2: The character length is `cfg_len` bits for values 2..16. A value of 0 or 1 acts as 2, and a value of 17..31 acts as 16. It is read while no character is in progress.
- R3: `mosi` is sampled on each rising `sclk` edge, first bit = most significant. After the last bit of a character, the word is placed right-aligned in `rx_data` (upper bits zero) and `rx_valid` is set. `rx_rd` clears `rx_valid`, but a completion in the same cycle leaves it set.
- R4: `miso_oe` is 1 from the recognised chip-select assertion until the recognised release. While it is 1, `miso_o` presents bit len-1 of the word last written through `tx_wr` first. It advances one bit on each falling `sclk` edge that follows a rising edge within the character. The word is reloaded when a character completes.
- R5: `rdy_o` (0 = ready) goes to 0 on `tx_wr` and goes to 1 when a character completes.
- R6: With `cfg_rdy_hiz`=0, `rdy_oe` is always 1 (push-pull). With `cfg_rdy_hiz`=1, `rdy_oe` is 1 only while `rdy_o` is 0 (shared-line mode).
- R7: A chip-select release with the bit counter mid-character enters an early-release state. While in it and `cfg_hiz_on_err`=1, `rdy_oe` is 0. The next chip-select assertion leaves the state. The partial character never sets `rx_valid`.
- R8: In the early-release state, any `sclk` edge while deselected sets the sticky `len_err` and discards the partial character. The next selection starts at bit len-1 again.
- R9: `err_clr` clears `len_err`. A set and a clear in the same cycle leave `len_err` at 1.
- R10: `irq` is 1 exactly while `len_err`=1 and `cfg_irq_en`=1.
- R11: Pin changes act on the outputs at the third rising system-clock edge after the change. A release at a character boundary followed by `sclk` edges sets no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk | input | 1 | Serial clock from master, idle low |
| cs_n | input | 1 | Chip select, active low |
| mosi | input | 1 | Serial data from master |
| miso_o | output | 1 | Serial data to master |
| miso_oe | output | 1 | Drive enable for `miso_o` |
| rdy_o | output | 1 | Ready line level, 0 = ready |
| rdy_oe | output | 1 | Drive enable for `rdy_o` |
| cfg_len | input | 5 | Character length in bits |
| cfg_rdy_hiz | input | 1 | 1 = ready line drives only its low level |
| cfg_hiz_on_err | input | 1 | 1 = release ready line on early release |
| cfg_irq_en | input | 1 | Length-error interrupt enable |
| tx_wr | input | 1 | Write strobe for transmit word |
| tx_data | input | 16 | Transmit word |
| rx_rd | input | 1 | Read strobe, clears `rx_valid` |
| rx_data | output | 16 | Last received word |
| rx_valid | output | 1 | Receive buffer holds an unread word |
| err_clr | input | 1 | Clear strobe for `len_err` |
| len_err | output | 1 | Sticky length-error flag |
| irq | output | 1 | Interrupt request |

## Verification
Two functions can meet in the same cycle: the length-error set caused by a synchronised clock edge after an early release, and the host's clear strobe. The bench raises `sclk` while deselected in the early-release state. It then times `err_clr` so that it is captured at the very system edge where the synchronised rising edge reaches the error logic. That cycle is found by counting the two synchroniser stages and the edge-detect register. The result is judged by the flag still reading 1 afterwards, both by a direct check and by the per-clock reference model, which applies set-over-clear priority on its own.

// File: rtl/spi_lenchk_pkg.sv
// Shared types for the SPI slave with character-length guard.
// Assumes: one system clock domain; link pins are asynchronous to it.
package spi_lenchk_pkg;

    // Pin events after synchronisation, one system cycle wide each
    typedef struct packed {
        logic sck_rise;   // serial clock went 0 -> 1
        logic sck_fall;   // serial clock went 1 -> 0
        logic sel_start;  // chip select became active
        logic sel_end;    // chip select became inactive
        logic sel_idle;   // chip select currently inactive
        logic sdi;        // synchronised serial data input
    } spi_evt_t;

endpackage

// File: rtl/spi_lenchk_sync.sv
// Brings sclk, cs_n and mosi into the system clock domain through STAGES
// flops and derives one-cycle edge events from the last stage.
// Assumes: system clock at least 4x the serial clock; idle sclk low, cs_n high.
module spi_lenchk_sync
    import spi_lenchk_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     sclk,
    input  logic     cs_n,
    input  logic     mosi,
    output spi_evt_t evt
);
    localparam logic [2:0] IDLE_PINS = 3'b010;  // {sclk, cs_n, mosi}

    logic [2:0] stg [STAGES+1];
    logic [2:0] cur;
    logic [2:0] prev;

    // Purpose: shift pin samples through the synchroniser and edge-delay flop
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i <= STAGES; i++) stg[i] <= IDLE_PINS;
        end else begin
            stg[0] <= {sclk, cs_n, mosi};
            for (int i = 1; i <= STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign cur  = stg[STAGES-1];
    assign prev = stg[STAGES];

    // Purpose: decode level changes into single-cycle events
    always_comb begin
        evt.sck_rise  = cur[2] & ~prev[2];
        evt.sck_fall  = ~cur[2] & prev[2];
        evt.sel_start = ~cur[1] & prev[1];
        evt.sel_end   = cur[1] & ~prev[1];
        evt.sel_idle  = cur[1];
        evt.sdi       = cur[0];
    end

endmodule

// File: rtl/spi_lenchk_engine.sv
// Character engine: bit counter, transmit and receive shifters, receive
// buffer with valid flag, transmit holding word and ready-line level.
// Assumes: len_eff already clamped to 2..DATA_W; abort only arrives while
// deselected.
module spi_lenchk_engine
    import spi_lenchk_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int LEN_W  = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  spi_evt_t          evt,
    input  logic              abort,
    input  logic [LEN_W-1:0]  len_eff,
    input  logic              tx_wr,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              rx_rd,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              miso_bit,
    output logic              selected,
    output logic              rdy_level,
    output logic              mid_char
);
    logic [LEN_W-1:0]  cnt_q;
    logic [DATA_W-1:0] tx_buf_q;
    logic [DATA_W-1:0] tx_sh_q;
    logic [DATA_W-1:0] rx_sh_q;
    logic [DATA_W-1:0] len_mask;
    logic [DATA_W-1:0] rx_next;
    logic [LEN_W-1:0]  pad;
    logic              last_bit;
    logic              shift_in;
    logic              char_done;

    // Purpose: mask of the low len_eff bits for the received word
    always_comb begin
        for (int i = 0; i < DATA_W; i++) len_mask[i] = (LEN_W'(i) < len_eff);
    end

    assign pad       = LEN_W'(DATA_W) - len_eff;
    assign last_bit  = (cnt_q == (len_eff - LEN_W'(1)));
    assign shift_in  = selected & evt.sck_rise & ~evt.sel_start & ~evt.sel_end;
    assign char_done = shift_in & last_bit;
    assign rx_next   = {rx_sh_q[DATA_W-2:0], evt.sdi};

    // Purpose: selection state, bit counter and both shift registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            selected <= 1'b0;
            cnt_q    <= '0;
            tx_sh_q  <= '0;
            rx_sh_q  <= '0;
        end else if (evt.sel_start) begin
            selected <= 1'b1;
            cnt_q    <= '0;
            tx_sh_q  <= tx_buf_q << pad;
            rx_sh_q  <= '0;
        end else if (evt.sel_end) begin
            selected <= 1'b0;
        end else if (abort) begin
            cnt_q <= '0;
        end else if (shift_in) begin
            rx_sh_q <= rx_next;
            if (last_bit) begin
                cnt_q   <= '0;
                tx_sh_q <= tx_buf_q << pad;
            end else begin
                cnt_q <= cnt_q + LEN_W'(1);
            end
        end else if (selected && evt.sck_fall && cnt_q != '0) begin
            tx_sh_q <= tx_sh_q << 1;
        end
    end

    // Purpose: receive buffer and its valid flag (completion beats read)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data  <= '0;
            rx_valid <= 1'b0;
        end else begin
            if (char_done) rx_data <= rx_next & len_mask;
            if (char_done)  rx_valid <= 1'b1;
            else if (rx_rd) rx_valid <= 1'b0;
        end
    end

    // Purpose: transmit holding word and ready level (write beats completion)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_buf_q  <= '0;
            rdy_level <= 1'b1;
        end else begin
            if (tx_wr) tx_buf_q <= tx_data;
            if (tx_wr)          rdy_level <= 1'b0;
            else if (char_done) rdy_level <= 1'b1;
        end
    end

    assign miso_bit = tx_sh_q[DATA_W-1];
    assign mid_char = (cnt_q != '0);

    assert_cnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < LEN_W'(DATA_W));
    assert_valid_after_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
        char_done |=> rx_valid);
    assert_release_drops_sel_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (evt.sel_end && !evt.sel_start) |=> !selected);
    assert_rdy_high_after_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (char_done && !tx_wr) |=> rdy_level);

endmodule

// File: rtl/spi_lenchk_guard.sv
// Length guard: tracks release of chip select in mid-character, turns later
// serial clock edges into an abort plus a sticky error, gates the interrupt
// and computes the ready-line drive enable.
// Assumes: mid_char is the engine's registered bit-count-nonzero state.
module spi_lenchk_guard
    import spi_lenchk_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  spi_evt_t evt,
    input  logic     mid_char,
    input  logic     err_clr,
    input  logic     irq_en,
    input  logic     hiz_on_err,
    input  logic     rdy_hiz_mode,
    input  logic     rdy_level,
    output logic     abort,
    output logic     early,
    output logic     len_err,
    output logic     irq,
    output logic     rdy_oe
);
    // Purpose: enter early-release state on mid-character release, leave on select
    always_ff @(posedge clk) begin
        if (!rst_n)                        early <= 1'b0;
        else if (evt.sel_start)            early <= 1'b0;
        else if (evt.sel_end && mid_char)  early <= 1'b1;
    end

    assign abort = early & evt.sel_idle & (evt.sck_rise | evt.sck_fall);

    // Purpose: sticky length error, setting wins over clearing
    always_ff @(posedge clk) begin
        if (!rst_n)       len_err <= 1'b0;
        else if (abort)   len_err <= 1'b1;
        else if (err_clr) len_err <= 1'b0;
    end

    assign irq    = len_err & irq_en;
    assign rdy_oe = ~(early & hiz_on_err) & (rdy_hiz_mode ? ~rdy_level : 1'b1);

    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (len_err && !err_clr) |=> len_err);
    assert_err_from_early_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(len_err) |-> $past(early));

endmodule

// File: rtl/spi_lenchk_slave.sv
// Top: SPI slave with programmable character length and early-release
// length-error detection. Clamps the configured length, wires the
// synchroniser, the character engine and the length guard.
// Assumes: configuration inputs change only while no character is active.
module spi_lenchk_slave
    import spi_lenchk_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int SYNC_STG  = 2,
    parameter int LEN_W     = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              cs_n,
    input  logic              mosi,
    output logic              miso_o,
    output logic              miso_oe,
    output logic              rdy_o,
    output logic              rdy_oe,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic              cfg_rdy_hiz,
    input  logic              cfg_hiz_on_err,
    input  logic              cfg_irq_en,
    input  logic              tx_wr,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              rx_rd,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    input  logic              err_clr,
    output logic              len_err,
    output logic              irq
);
    localparam logic [LEN_W-1:0] LEN_MIN = LEN_W'(2);
    localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(DATA_W);

    spi_evt_t         evt;
    logic [LEN_W-1:0] len_eff;
    logic             abort;
    logic             early;
    logic             mid_char;
    logic             selected;

    // Purpose: clamp the configured character length into 2..DATA_W
    always_comb begin
        if (cfg_len < LEN_MIN)      len_eff = LEN_MIN;
        else if (cfg_len > LEN_MAX) len_eff = LEN_MAX;
        else                        len_eff = cfg_len;
    end

    spi_lenchk_sync #(.STAGES(SYNC_STG)) sync_i (
        .clk (clk), .rst_n (rst_n), .sclk (sclk), .cs_n (cs_n), .mosi (mosi),
        .evt (evt)
    );

    spi_lenchk_engine #(.DATA_W(DATA_W), .LEN_W(LEN_W)) engine_i (
        .clk (clk), .rst_n (rst_n), .evt (evt), .abort (abort),
        .len_eff (len_eff), .tx_wr (tx_wr), .tx_data (tx_data), .rx_rd (rx_rd),
        .rx_data (rx_data), .rx_valid (rx_valid), .miso_bit (miso_o),
        .selected (selected), .rdy_level (rdy_o), .mid_char (mid_char)
    );

    spi_lenchk_guard guard_i (
        .clk (clk), .rst_n (rst_n), .evt (evt), .mid_char (mid_char),
        .err_clr (err_clr), .irq_en (cfg_irq_en), .hiz_on_err (cfg_hiz_on_err),
        .rdy_hiz_mode (cfg_rdy_hiz), .rdy_level (rdy_o), .abort (abort),
        .early (early), .len_err (len_err), .irq (irq), .rdy_oe (rdy_oe)
    );

    assign miso_oe = selected;

    assert_rdy_released_on_early_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (early && cfg_hiz_on_err) |-> !rdy_oe);
    assert_no_drive_when_early_R7: assert property (@(posedge clk) disable iff (!rst_n)
        early |-> !miso_oe);

endmodule

// File: tb/spi_lenchk_slave_tb_top.sv
// Bench: behavioural per-clock reference model compared on every negedge,
// plus directed checks at scenario points. Inputs change 2 ns after posedge.
module spi_lenchk_slave_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic miso_o, miso_oe, rdy_o, rdy_oe;
    logic [4:0]  cfg_len = 5'd8;
    logic cfg_rdy_hiz = 1'b0, cfg_hiz_on_err = 1'b1, cfg_irq_en = 1'b1;
    logic tx_wr = 1'b0, rx_rd = 1'b0, err_clr = 1'b0;
    logic [15:0] tx_data = '0;
    logic [15:0] rx_data;
    logic rx_valid, len_err, irq;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;  // 50 MHz

    spi_lenchk_slave dut_i (
        .clk (clk), .rst_n (rst_n), .sclk (sclk), .cs_n (cs_n), .mosi (mosi),
        .miso_o (miso_o), .miso_oe (miso_oe), .rdy_o (rdy_o), .rdy_oe (rdy_oe),
        .cfg_len (cfg_len), .cfg_rdy_hiz (cfg_rdy_hiz),
        .cfg_hiz_on_err (cfg_hiz_on_err), .cfg_irq_en (cfg_irq_en),
        .tx_wr (tx_wr), .tx_data (tx_data), .rx_rd (rx_rd),
        .rx_data (rx_data), .rx_valid (rx_valid), .err_clr (err_clr),
        .len_err (len_err), .irq (irq)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic int eff_len(input int v);
        if (v < 2) return 2;
        if (v > 16) return 16;
        return v;
    endfunction

    function automatic logic [15:0] msk(input int n);
        return (n >= 16) ? 16'hFFFF : 16'((32'd1 << n) - 1);
    endfunction

    // ---------------- reference model ----------------
    bit h_sck [4] = '{default: 1'b0};
    bit h_cs  [4] = '{default: 1'b1};
    bit h_mo  [4] = '{default: 1'b0};
    bit h_rst = 0, h_wr = 0, h_rd = 0, h_clr = 0;
    logic [15:0] h_dat = '0;

    bit m_sel, m_early, m_err, m_valid, m_rdy;
    int m_cnt;
    logic [15:0] m_txbuf, m_txsh, m_rxsh, m_rxdata;

    always @(negedge clk) begin
        int len;
        bit rise, fall, start, stop, idle, sdi, abort, done;
        bit exp_oe;
        if (!h_rst) begin
            m_sel = 0; m_early = 0; m_err = 0; m_valid = 0; m_rdy = 1; m_cnt = 0;
            m_txbuf = '0; m_txsh = '0; m_rxsh = '0; m_rxdata = '0;
            for (int k = 0; k < 4; k++) begin h_sck[k] = 0; h_cs[k] = 1; h_mo[k] = 0; end
        end else begin
            len   = eff_len(int'(cfg_len));
            rise  = h_sck[2] && !h_sck[3];
            fall  = !h_sck[2] && h_sck[3];
            start = !h_cs[2] && h_cs[3];
            stop  = h_cs[2] && !h_cs[3];
            idle  = h_cs[2];
            sdi   = h_mo[2];
            abort = m_early && idle && (rise || fall);
            done  = 0;
            if (abort) m_err = 1; else if (h_clr) m_err = 0;
            if (start) m_early = 0; else if (stop && m_cnt != 0) m_early = 1;
            if (start) begin
                m_sel = 1; m_cnt = 0; m_txsh = m_txbuf << (16 - len); m_rxsh = '0;
            end else if (stop) begin
                m_sel = 0;
            end else if (abort) begin
                m_cnt = 0;
            end else if (m_sel && rise) begin
                m_rxsh = {m_rxsh[14:0], sdi};
                if (m_cnt == len - 1) begin
                    done = 1; m_cnt = 0; m_txsh = m_txbuf << (16 - len);
                    m_rxdata = m_rxsh & msk(len);
                end else m_cnt++;
            end else if (m_sel && fall && m_cnt != 0) begin
                m_txsh = m_txsh << 1;
            end
            if (done) m_valid = 1; else if (h_rd) m_valid = 0;
            if (h_wr) m_rdy = 0; else if (done) m_rdy = 1;
            if (h_wr) m_txbuf = h_dat;
        end
        // per-clock comparison
        chk("R4", "miso_oe", miso_oe, m_sel);
        if (m_sel) chk("R4", "miso_o", miso_o, m_txsh[15]);
        chk("R5", "rdy_o", rdy_o, m_rdy);
        exp_oe = (m_early && cfg_hiz_on_err) ? 1'b0 : (cfg_rdy_hiz ? !m_rdy : 1'b1);
        chk((m_early && cfg_hiz_on_err) ? "R7" : "R6", "rdy_oe", rdy_oe, exp_oe);
        chk("R3", "rx_valid", rx_valid, m_valid);
        chk("R3", "rx_data", rx_data, m_rxdata);
        chk("R8", "len_err", len_err, m_err);
        chk("R10", "irq", irq, m_err && cfg_irq_en);
        // capture pins for the next posedge (R11 latency: two sync stages + edge flop)
        for (int k = 3; k > 0; k--) begin
            h_sck[k] = h_sck[k-1]; h_cs[k] = h_cs[k-1]; h_mo[k] = h_mo[k-1];
        end
        h_sck[0] = sclk; h_cs[0] = cs_n; h_mo[0] = mosi;
        h_rst = rst_n; h_wr = tx_wr; h_dat = tx_data; h_rd = rx_rd; h_clr = err_clr;
    end

    // ---------------- stimulus helpers ----------------
    task automatic step(input int n);
        repeat (n) begin @(posedge clk); #2; end
    endtask

    task automatic host_wr(input logic [15:0] v);
        tx_data = v; tx_wr = 1'b1; step(1); tx_wr = 1'b0;
    endtask

    task automatic host_rd();
        rx_rd = 1'b1; step(1); rx_rd = 1'b0;
    endtask

    task automatic sel(input bit on);
        cs_n = !on; step(6);
    endtask

    task automatic xfer(input int nb, input logic [15:0] din, output logic [15:0] dout);
        dout = '0;
        for (int i = nb - 1; i >= 0; i--) begin
            mosi = din[i]; step(4);
            dout = {dout[14:0], miso_o};
            sclk = 1'b1; step(4); sclk = 1'b0;
        end
        step(4);
    endtask

    task automatic pulse_sclk();
        sclk = 1'b1; step(4); sclk = 1'b0; step(4);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog R11 actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    // ---------------- scenarios ----------------
    initial begin
        logic [15:0] got;
        step(4);
        rst_n = 1'b1;
        step(2);
        // R1: reset state
        chk("R1", "miso_oe", miso_oe, 0);
        chk("R1", "rdy_o", rdy_o, 1);
        chk("R1", "rx_valid", rx_valid, 0);
        chk("R1", "rx_data", rx_data, 0);
        chk("R1", "len_err", len_err, 0);
        chk("R1", "irq", irq, 0);

        // R3/R4/R5: 8-bit character, push-pull ready line
        host_wr(16'h003C);
        chk("R5", "rdy_o after write", rdy_o, 0);
        sel(1);
        xfer(8, 16'h00A5, got);
        chk("R3", "rx_data 8b", rx_data, 16'h00A5);
        chk("R3", "rx_valid 8b", rx_valid, 1);
        chk("R4", "miso word 8b", got, 16'h003C);
        chk("R5", "rdy_o after char", rdy_o, 1);
        sel(0);
        chk("R11", "no error at boundary", len_err, 0);
        pulse_sclk();
        chk("R11", "edge after clean release", len_err, 0);
        host_rd();
        chk("R3", "rx_valid after read", rx_valid, 0);

        // R2: 16-bit, clamp low, clamp high
        cfg_len = 5'd16; host_wr(16'hBEEF); sel(1);
        xfer(16, 16'h1234, got); sel(0);
        chk("R2", "rx_data 16b", rx_data, 16'h1234);
        chk("R4", "miso word 16b", got, 16'hBEEF);
        cfg_len = 5'd0; host_wr(16'hFFFE); sel(1);
        xfer(2, 16'h0002, got); sel(0);
        chk("R2", "rx_data len0->2", rx_data, 16'h0002);
        chk("R2", "miso word len0->2", got, 16'h0002);
        cfg_len = 5'd20; host_wr(16'h8001); sel(1);
        xfer(16, 16'hC3A5, got); sel(0);
        chk("R2", "rx_data len20->16", rx_data, 16'hC3A5);

        // R6: shared-line ready mode
        cfg_len = 5'd8; cfg_rdy_hiz = 1'b1; step(1);
        chk("R6", "rdy_oe released while not ready", rdy_oe, 0);
        host_wr(16'h0055); step(1);
        chk("R6", "rdy_oe drives low when ready", rdy_oe, 1);
        cfg_rdy_hiz = 1'b0;

        // R7/R8/R10: early release then clock edge
        host_rd();
        sel(1);
        xfer(3, 16'h0005, got);
        sel(0);
        chk("R7", "rdy_oe on early release", rdy_oe, 0);
        chk("R7", "miso_oe on early release", miso_oe, 0);
        chk("R7", "no valid for partial", rx_valid, 0);
        chk("R8", "no error before edge", len_err, 0);
        pulse_sclk();
        chk("R8", "error after edge", len_err, 1);
        chk("R10", "irq enabled", irq, 1);
        cfg_irq_en = 1'b0; step(1);
        chk("R10", "irq masked", irq, 0);
        cfg_irq_en = 1'b1;
        host_wr(16'h0081); sel(1);
        chk("R7", "rdy_oe back after select", rdy_oe, 1);
        xfer(8, 16'h005A, got); sel(0);
        chk("R8", "fresh char after abort", rx_data, 16'h005A);
        chk("R8", "fresh miso after abort", got, 16'h0081);
        chk("R8", "error still sticky", len_err, 1);

        // R9: clear alone, then set and clear in the same cycle
        err_clr = 1'b1; step(1); err_clr = 1'b0; step(1);
        chk("R9", "cleared", len_err, 0);
        sel(1); xfer(2, 16'h0003, got); sel(0);
        sclk = 1'b1; step(2);
        err_clr = 1'b1; step(1); err_clr = 1'b0;
        step(4); sclk = 1'b0; step(4);
        chk("R9", "set beats clear", len_err, 1);
        err_clr = 1'b1; step(1); err_clr = 1'b0; step(1);
        chk("R9", "cleared again", len_err, 0);

        // R3: completion and read in the same cycle keeps valid
        host_wr(16'h00F0); sel(1);
        xfer(7, 16'h0011, got);
        mosi = 1'b1; step(4); sclk = 1'b1; step(2);
        rx_rd = 1'b1; step(1); rx_rd = 1'b0; step(1); sclk = 1'b0; step(4);
        sel(0);
        chk("R3", "valid kept on collision", rx_valid, 1);
        chk("R3", "rx_data collision", rx_data, 16'h0023);

        step(4);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule